// File: doc/BRIEF.md
# Watchdog Reset Gate with Reset-Cause Record

This block sits on the always-on power-management side, between a watchdog timer and the system reset controller. The watchdog raises a reset request when it expires. The block decides from three programmable control bits whether that request reaches the reset controller. The first is a mask bit whose polarity is fixed when the block is built. The second is an auto-disable bit, which suppresses the request while the target processor is already held in reset. The third is a counter-enable bit, driven out to let the watchdog counter run.

The block also keeps a sticky cause flag. The flag is set when a watchdog reset is forwarded, and it survives the system reset that follows because the block is reset only by power-on reset. Software reads the flag after boot to find out why the processor restarted, and clears it by writing one. Both registers sit on a simple single-cycle write port with a combinational read port. A forwarded request is combinational, so it reaches the reset controller in the same cycle it arrives.

Top module: `wdg_reset_gate`

## Requirements
- R1: While and after power-on reset (`rst_n` low), the control word reads the mask bit (bit 2) equal to the polarity parameter `INVERT_MASK`, the auto-disable bit (bit 0) as 0 and the counter-enable bit (bit 7) as 0. The status word reads 0 and `wdog_cnt_en_o` is low, so with the default settings a request is forwarded.
- R2: With `INVERT_MASK` = 0, a control bit 2 of 1 blocks the request and a value of 0 forwards it.
- R3: With `INVERT_MASK` = 1, a control bit 2 of 1 forwards the request and a value of 0 blocks it.
- R4: When control bit 0 (auto-disable) is 1 and `cpu_in_rst_i` is high, no request is forwarded, whatever the mask says. When `cpu_in_rst_i` is low, the auto-disable bit has no effect.
- R5: `wdog_cnt_en_o` equals control bit 7, starting from the clock edge that accepts a control write.
- R6: `sys_rst_req_o` follows `wdog_req_i` combinationally, in the same cycle, when the gates are open, and it is never high while `wdog_req_i` is low.
- R7: Status bit 9 (watchdog cause) becomes 1 at the clock edge where `sys_rst_req_o` is high. It then stays 1 after the request drops.
- R8: A status write with data bit 9 = 1 clears the cause bit, and a status write with bit 9 = 0 leaves it unchanged. If a forwarded request arrives in the same cycle as the clear, the bit stays set.
- R9: A request that is blocked by the mask or by auto-disable never sets the cause bit.
- R10: The control word is at address 0 and the status word at address 4. All other bits read 0, any other address reads 0, and writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| cfg_wr | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | ADDR_W | Register address (0 control, 4 status) |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Combinational read data for `cfg_addr` |
| wdog_req_i | input | 1 | Reset request from the watchdog |
| cpu_in_rst_i | input | 1 | High while the target processor is held in reset |
| sys_rst_req_o | output | 1 | Gated reset request to the reset controller |
| wdog_cnt_en_o | output | 1 | Enable that lets the watchdog counter run |

## Verification
A wrong control bit shows up within one cycle. It appears directly on `sys_rst_req_o` or `wdog_cnt_en_o`, and also in the control word read back at address 0. A corrupted or non-sticky cause flag gives no sign on the gating outputs. It can only be seen by reading address 4, possibly many cycles after the request that should have set it. The bench therefore reads the status word continually throughout random traffic. Two instances with opposite mask polarity receive the same stimulus, so any polarity swap shows as a mismatch on the very first gated request.

// File: rtl/wdg_gate_pkg.sv
package wdg_gate_pkg;

  // Gating controls held in the control register.
  typedef struct packed {
    logic mask;    // polarity set by INVERT_MASK
    logic adis;    // suppress while processor is in reset
    logic cnt_en;  // let the watchdog counter run
  } gate_ctrl_t;

endpackage

// File: rtl/wdg_gate_ctrl_regs.sv
module wdg_gate_ctrl_regs
  import wdg_gate_pkg::*;
#(
  parameter bit INVERT_MASK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  gate_ctrl_t wfields_i,
  output gate_ctrl_t ctrl_o
);

  // Safe state: request forwarded, counter stopped.
  localparam gate_ctrl_t RST_VAL = '{mask: INVERT_MASK, adis: 1'b0, cnt_en: 1'b0};

  gate_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = wfields_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= RST_VAL;
    else if (wr_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_CNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ctrl_o.cnt_en == $past(wfields_i.cnt_en))); // R5

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_o)); // R10

endmodule

// File: rtl/wdg_gate_path.sv
module wdg_gate_path
  import wdg_gate_pkg::*;
#(
  parameter bit INVERT_MASK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gate_ctrl_t ctrl_i,
  input  logic       req_i,
  input  logic       cpu_rst_i,
  output logic       fwd_o
);

  logic allow;
  logic suppress;

  generate
    if (INVERT_MASK) begin : g_active_high
      assign allow = ctrl_i.mask;
    end else begin : g_active_low
      assign allow = ~ctrl_i.mask;
    end
  endgenerate

  assign suppress = ctrl_i.adis & cpu_rst_i;
  assign fwd_o    = req_i & allow & ~suppress;

  AST_NO_FWD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> req_i); // R6

  AST_ADIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.adis && cpu_rst_i) |-> !fwd_o); // R4

endmodule

// File: rtl/wdg_cause_capture.sv
module wdg_cause_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_i,
  input  logic clr_i,
  output logic cause_o
);

  logic cause_q, cause_d, cause_en;

  // A new forwarded reset takes priority over a clear in the same cycle.
  always_comb begin
    cause_en = fwd_i | clr_i;
    cause_d  = fwd_i | (cause_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= 1'b0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  AST_CAUSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_i |=> cause_o); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o && !clr_i) |=> cause_o); // R8

  AST_CAUSE_NEEDS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_o) |-> $past(fwd_i)); // R9

endmodule

// File: rtl/wdg_reset_gate.sv
module wdg_reset_gate
  import wdg_gate_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int CTRL_ADDR   = 0,
  parameter int STAT_ADDR   = 4,
  parameter int MASK_POS    = 2,
  parameter int ADIS_POS    = 0,
  parameter int CNT_POS     = 7,
  parameter int CAUSE_POS   = 9,
  parameter bit INVERT_MASK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              wdog_req_i,
  input  logic              cpu_in_rst_i,
  output logic              sys_rst_req_o,
  output logic              wdog_cnt_en_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  gate_ctrl_t ctrl, wfields;
  logic       hit_ctrl, hit_stat;
  logic       wr_ctrl, clr_cause;
  logic       fwd, cause;

  assign hit_ctrl  = (cfg_addr == CTRL_A);
  assign hit_stat  = (cfg_addr == STAT_A);
  assign wr_ctrl   = cfg_wr & hit_ctrl;
  assign clr_cause = cfg_wr & hit_stat & cfg_wdata[CAUSE_POS];

  assign wfields = '{mask:   cfg_wdata[MASK_POS],
                     adis:   cfg_wdata[ADIS_POS],
                     cnt_en: cfg_wdata[CNT_POS]};

  wdg_gate_ctrl_regs #(.INVERT_MASK(INVERT_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_ctrl),
    .wfields_i (wfields),
    .ctrl_o    (ctrl)
  );

  wdg_gate_path #(.INVERT_MASK(INVERT_MASK)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_i    (ctrl),
    .req_i     (wdog_req_i),
    .cpu_rst_i (cpu_in_rst_i),
    .fwd_o     (fwd)
  );

  wdg_cause_capture u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .fwd_i   (fwd),
    .clr_i   (clr_cause),
    .cause_o (cause)
  );

  always_comb begin
    cfg_rdata = '0;
    if (hit_ctrl) begin
      cfg_rdata[MASK_POS] = ctrl.mask;
      cfg_rdata[ADIS_POS] = ctrl.adis;
      cfg_rdata[CNT_POS]  = ctrl.cnt_en;
    end else if (hit_stat) begin
      cfg_rdata[CAUSE_POS] = cause;
    end
  end

  assign sys_rst_req_o = fwd;
  assign wdog_cnt_en_o = ctrl.cnt_en;

  AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !hit_ctrl) |=> $stable(wdog_cnt_en_o)); // R10

  AST_CNT_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(wdog_cnt_en_o)); // R5

endmodule

// File: tb/test_wdg_reset_gate.sv
`timescale 1ns/1ps
module test_wdg_reset_gate;

  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic          wdog_req, cpu_rst;
  logic [DW-1:0] rdata [2];
  logic          fwd   [2];
  logic          cnt   [2];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference state: index 0 normal polarity, 1 inverted.
  logic m_mask [2];
  logic m_adis, m_cnt;
  logic m_cause [2];

  always #2.5 clk = ~clk;

  wdg_reset_gate #(.INVERT_MASK(1'b0)) i_wdg_reset_gate (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata[0]), .wdog_req_i(wdog_req),
    .cpu_in_rst_i(cpu_rst), .sys_rst_req_o(fwd[0]), .wdog_cnt_en_o(cnt[0]));

  wdg_reset_gate #(.INVERT_MASK(1'b1)) i_wdg_reset_gate_inv (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata[1]), .wdog_req_i(wdog_req),
    .cpu_in_rst_i(cpu_rst), .sys_rst_req_o(fwd[1]), .wdog_cnt_en_o(cnt[1]));

  function automatic logic exp_fwd(int k);
    logic open_gate;
    open_gate = (k == 1) ? m_mask[k] : !m_mask[k];
    return wdog_req & open_gate & !(m_adis & cpu_rst);
  endfunction

  function automatic logic [DW-1:0] exp_read(int k);
    logic [DW-1:0] w;
    w = '0;
    if (cfg_addr == 4'd0) begin
      w[2] = m_mask[k]; w[0] = m_adis; w[7] = m_cnt;
    end else if (cfg_addr == 4'd4) begin
      w[9] = m_cause[k];
    end
    return w;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge with inputs already driven.
  task automatic step(string tag);
    logic f [2];
    logic clr;
    #1;
    for (int k = 0; k < 2; k++) begin
      f[k] = exp_fwd(k);
      check(tag, DW'(fwd[k]), DW'(f[k]));
      check("R5 counter enable", DW'(cnt[k]), DW'(m_cnt));
      check((cfg_addr == 4'd4) ? "R7 status read" : "R10 control read",
            rdata[k], exp_read(k));
    end
    @(posedge clk);
    clr = cfg_wr && (cfg_addr == 4'd4) && cfg_wdata[9];
    for (int k = 0; k < 2; k++) m_cause[k] = f[k] | (m_cause[k] & !clr);
    if (cfg_wr && cfg_addr == 4'd0) begin
      m_mask[0] = cfg_wdata[2]; m_mask[1] = cfg_wdata[2];
      m_adis = cfg_wdata[0]; m_cnt = cfg_wdata[7];
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(tag);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    wdog_req = 1'b0; cpu_rst = 1'b0;
    m_mask[0] = 1'b0; m_mask[1] = 1'b1; m_adis = 1'b0; m_cnt = 1'b0;
    m_cause[0] = 1'b0; m_cause[1] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset values
    check("R1 ctrl normal", rdata[0], 32'h0000_0000);
    check("R1 ctrl inverted", rdata[1], 32'h0000_0004);
    check("R1 cnt_en", DW'(cnt[0] | cnt[1]), '0);
    cfg_addr = 4'd4;
    #1;
    check("R1 status", rdata[0] | rdata[1], '0);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_addr = 4'd0;

    // R6: request passes in default state
    wdog_req = 1'b0; step("R6 idle");
    cfg_addr = 4'd4;
    wdog_req = 1'b1; step("R6 forward");
    wdog_req = 1'b0; step("R7 sticky after drop");
    // R8: write 0 keeps, write 1 clears, set wins over clear
    wr(4'd4, 32'h0000_0000, "R8 write zero");
    wr(4'd4, 32'h0000_0200, "R8 clear");
    step("R8 cleared");
    wdog_req = 1'b1;
    wr(4'd4, 32'h0000_0200, "R8 set wins");
    wdog_req = 1'b0; step("R8 set won");
    wr(4'd4, 32'h0000_0200, "R8 clear again");

    // R2/R3: mask set
    wr(4'd0, 32'h0000_0004, "R2 write mask");
    wdog_req = 1'b1; step("R2 R3 mask set");
    wdog_req = 1'b0; step("R9 cause only on inverted");
    wr(4'd4, 32'h0000_0200, "R8 clear");
    wr(4'd0, 32'h0000_0000, "R3 mask clear");
    wdog_req = 1'b1; step("R2 R3 mask clear");
    wdog_req = 1'b0;
    wr(4'd4, 32'h0000_0200, "R8 clear");

    // R4: auto-disable
    wr(4'd0, 32'h0000_0001, "R4 write adis");
    wdog_req = 1'b1; cpu_rst = 1'b1; step("R4 suppressed");
    cpu_rst = 1'b0; step("R4 not in reset");
    wdog_req = 1'b0; step("R9 status after adis");
    wr(4'd4, 32'h0000_0200, "R8 clear");
    wr(4'd0, 32'h0000_0005, "R4 adis plus mask");
    wdog_req = 1'b1; cpu_rst = 1'b1; step("R4 suppressed inverted");
    wdog_req = 1'b0; cpu_rst = 1'b0; step("R9 no cause");

    // R5 counter enable and R10 unmapped writes
    wr(4'd0, 32'h0000_0080, "R5 enable counter");
    cfg_addr = 4'd0; step("R5 enabled");
    wr(4'd8, 32'hFFFF_FFFF, "R10 unmapped write");
    cfg_addr = 4'd0; step("R10 ctrl unchanged");
    cfg_addr = 4'd12; step("R10 unmapped read");
    wr(4'd0, 32'hFFFF_FF7B, "R5 disable counter");
    cfg_addr = 4'd0; step("R10 only defined bits");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      wdog_req = ($urandom % 3) == 0;
      cpu_rst  = ($urandom % 2) == 0;
      cfg_wr   = ($urandom % 4) == 0;
      cfg_addr = AW'(($urandom % 4) * 4);
      cfg_wdata = $urandom;
      step("R2 R3 R4 R6 random");
    end
    cfg_wr = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule